// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A combinational datapath element that turns two W-bit operands `a_i` and `b_i`, a carry input `cin_i` and a four-bit select `sel_i` into one W-bit result `f_o` and a carry output `cout_o`. The upper select pair `sel_i[3:2]` picks the section that drives the result:

- `00`: the arithmetic section.
- `01`: the bitwise logic section.
- `10`: a one-place right shift of `a_i`.
- `11`: a one-place left shift of `a_i`.

The lower pair `sel_i[1:0]` picks the operation within the arithmetic or logic section.

All arithmetic operations come from one adder that forms A + Y + Cin. The lower select pair chooses Y from B, the bitwise complement of B, all zeros or all ones, and the carry input refines the operation. A fixed per-bit 4:1 multiplexer then chooses between the adder bit, the logic bit and the two neighbouring operand bits. The shifts take their vacated end bit from a serial input for each direction. A host tying both serial inputs low gets zero fill.

The unit has no storage. Its outputs follow its inputs within the same cycle, so surrounding pipeline registers set the timing.

Top module: `alsu_unit`

## Requirements
- R1: With `sel_i`=0000, `f_o` = (A + B + Cin) mod 2^W and `cout_o` is bit W of that sum (Cin=0 adds, Cin=1 adds plus one).
- R2: With `sel_i`=0001, `f_o` = (A + ~B + Cin) mod 2^W, i.e. A−B−1 for Cin=0 and A−B for Cin=1. For unsigned A < B this is the two's complement of B−A. `cout_o` is bit W of A + (2^W−1−B) + Cin, which for Cin=1 is 1 exactly when A >= B.
- R3: With `sel_i`=0010, `f_o` = (A + Cin) mod 2^W (transfer or increment), and `cout_o` is bit W of A + Cin.
- R4: With `sel_i`=0011, `f_o` = (A + 2^W−1 + Cin) mod 2^W (decrement for Cin=0, transfer for Cin=1), and `cout_o` is 1 unless A=0 and Cin=0.
- R5: With `sel_i[3:2]`=01, `sel_i[1:0]` = 00/01/10/11 gives A AND B, A OR B, A XOR B, NOT A. `cout_o` is 0 and `cin_i` has no effect.
- R6: With `sel_i[3:2]`=10, `f_o[i]` = A[i+1] for i < W−1, and `f_o[W-1]` = `shr_fill_i`.
- R7: With `sel_i[3:2]`=11, `f_o[i]` = A[i−1] for i > 0, and `f_o[0]` = `shl_fill_i`.
- R8: For both shifts, `sel_i[1:0]` and `cin_i` have no effect and `cout_o` is 0. The fill input of the opposite direction is also ignored.
- R9: The unit is purely combinational: a new input set is reflected on `f_o` and `cout_o` within the same clock cycle, and W is a parameter (default 8, at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | Operand A, also the shift source |
| b_i | input | W | Operand B |
| cin_i | input | 1 | Adder carry input |
| sel_i | input | 4 | [3:2] section, [1:0] operation |
| shr_fill_i | input | 1 | Bit entering the MSB on a right shift |
| shl_fill_i | input | 1 | Bit entering the LSB on a left shift |
| f_o | output | W | Result |
| cout_o | output | 1 | Adder carry output, 0 outside arithmetic |

## Verification
The bench builds two instances: the default W=8 and a narrow W=3. At W=3 every combination of operands, carry, select and both fill bits is swept, which reaches every carry-chain wrap, every borrow case and both shift fills from all operand values. The 8-bit instance takes directed corners (zero, all ones, the A=B and A=B±1 subtract boundaries) and a long pseudo-random run against a behavioural integer model.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    SEC_ARITH = 2'b00,
    SEC_LOGIC = 2'b01,
    SEC_SHR   = 2'b10,
    SEC_SHL   = 2'b11
  } sec_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } lop_e;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NB   = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } ysel_e;
endpackage

// File: rtl/alsu_arith.sv
module alsu_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  input  logic         cin_i,
  output logic [W-1:0] d_o,
  output logic         cout_o
);
  import alsu_pkg::*;

  logic [W-1:0] y;
  logic [W:0]   sum;

  always_comb begin
    unique case (ysel_e'(op_i))
      YSEL_B:    y = b_i;
      YSEL_NB:   y = ~b_i;
      YSEL_ZERO: y = '0;
      default:   y = '1;
    endcase
  end

  // single adder serves every arithmetic operation
  assign sum    = {1'b0, a_i} + {1'b0, y} + {{W{1'b0}}, cin_i};
  assign d_o    = sum[W-1:0];
  assign cout_o = sum[W];
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] e_o
);
  import alsu_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (lop_e'(op_i))
        LOP_AND: e_o[i] = a_i[i] & b_i[i];
        LOP_OR:  e_o[i] = a_i[i] | b_i[i];
        LOP_XOR: e_o[i] = a_i[i] ^ b_i[i];
        default: e_o[i] = ~a_i[i];
      endcase
    end
  end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         shr_fill_i,
  input  logic         shl_fill_i,
  output logic [W-1:0] shr_o,
  output logic [W-1:0] shl_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign shr_o[i] = shr_fill_i;
    end else begin : g_mid_r
      assign shr_o[i] = a_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign shl_o[i] = shl_fill_i;
    end else begin : g_mid_l
      assign shl_o[i] = a_i[i-1];
    end
  end
endmodule

// File: rtl/alsu_unit.sv
module alsu_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [3:0]   sel_i,
  input  logic         shr_fill_i,
  input  logic         shl_fill_i,
  output logic [W-1:0] f_o,
  output logic         cout_o
);
  import alsu_pkg::*;

  logic [W-1:0] arith_d;
  logic         arith_c;
  logic [W-1:0] logic_e;
  logic [W-1:0] shr_v;
  logic [W-1:0] shl_v;
  sec_e         sec;

  assign sec = sec_e'(sel_i[3:2]);

  alsu_arith #(.W(W)) u_arith (
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (sel_i[1:0]),
    .cin_i (cin_i),
    .d_o   (arith_d),
    .cout_o(arith_c)
  );

  alsu_logic #(.W(W)) u_logic (
    .a_i (a_i),
    .b_i (b_i),
    .op_i(sel_i[1:0]),
    .e_o (logic_e)
  );

  alsu_shift #(.W(W)) u_shift (
    .a_i       (a_i),
    .shr_fill_i(shr_fill_i),
    .shl_fill_i(shl_fill_i),
    .shr_o     (shr_v),
    .shl_o     (shl_v)
  );

  // per-bit 4:1 section select
  for (genvar i = 0; i < W; i++) begin : g_fmux
    always_comb begin
      unique case (sec)
        SEC_ARITH: f_o[i] = arith_d[i];
        SEC_LOGIC: f_o[i] = logic_e[i];
        SEC_SHR:   f_o[i] = shr_v[i];
        default:   f_o[i] = shl_v[i];
      endcase
    end
  end

  assign cout_o = (sec == SEC_ARITH) && arith_c;

  // checks against independent formulations of the result
  logic [W-1:0] diff_ref;
  logic [W-1:0] dec_ref;
  always_comb begin
    diff_ref = a_i - b_i;
    dec_ref  = a_i - {{(W-1){1'b0}}, 1'b1};
    if (sel_i == 4'b0001 && cin_i) begin
      a_r2_sub_exact: assert (f_o == diff_ref && cout_o == (a_i >= b_i))
        else $error("a_r2_sub_exact");
    end
    if (sel_i == 4'b0011 && !cin_i) begin
      a_r4_decrement: assert (f_o == dec_ref && cout_o == (a_i != '0))
        else $error("a_r4_decrement");
    end
    if (sel_i == 4'b0110) begin
      a_r5_xor_undo: assert ((f_o ^ b_i) == a_i && !cout_o)
        else $error("a_r5_xor_undo");
    end
    if (sel_i[3:2] == 2'b10) begin
      a_r6_shr_chain: assert (f_o[W-2:0] == a_i[W-1:1] && !cout_o)
        else $error("a_r6_shr_chain");
    end
    if (sel_i[3:2] == 2'b11) begin
      a_r7_shl_chain: assert (f_o[W-1:1] == a_i[W-2:0] && !cout_o)
        else $error("a_r7_shl_chain");
    end
  end
endmodule

// File: tb/alsu_unit_tb.sv
module alsu_unit_tb;
  localparam int unsigned WA = 8;
  localparam int unsigned WB = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [WA-1:0] a8, b8, f8;
  logic          cin8, sr8, sl8, co8;
  logic [3:0]    s8;
  logic [WB-1:0] a3, b3, f3;
  logic          cin3, sr3, sl3, co3;
  logic [3:0]    s3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  alsu_unit #(.W(WA)) u_dut (
    .a_i(a8), .b_i(b8), .cin_i(cin8), .sel_i(s8),
    .shr_fill_i(sr8), .shl_fill_i(sl8), .f_o(f8), .cout_o(co8)
  );

  alsu_unit #(.W(WB)) u_dut_narrow (
    .a_i(a3), .b_i(b3), .cin_i(cin3), .sel_i(s3),
    .shr_fill_i(sr3), .shl_fill_i(sl3), .f_o(f3), .cout_o(co3)
  );

  // behavioural model: returns {cout, f} in bits [w:0]
  function automatic longint unsigned model(int w, longint unsigned a, longint unsigned b,
                                            bit cin, bit [3:0] s, bit sr, bit sl);
    longint unsigned m = (64'd1 << w) - 1;
    longint unsigned y;
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00: y = b;
          2'b01: y = m - b;
          2'b10: y = 0;
          default: y = m;
        endcase
        return (a + y + cin) & ((m << 1) | 1);
      end
      2'b01: begin
        case (s[1:0])
          2'b00: return a & b;
          2'b01: return a | b;
          2'b10: return a ^ b;
          default: return m - a;
        endcase
      end
      2'b10: return (a >> 1) | (longint'(sr) << (w - 1));
      default: return ((a << 1) & m) | sl;
    endcase
  endfunction

  function automatic string req_of(bit [3:0] s);
    case (s[3:2])
      2'b00: case (s[1:0])
               2'b00: return "R1";
               2'b01: return "R2";
               2'b10: return "R3";
               default: return "R4";
             endcase
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare(string req, longint unsigned got, longint unsigned exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {cout,f}=0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // drive after the edge, sample at the following falling edge (R9: same cycle)
  task automatic run8(logic [WA-1:0] a, logic [WA-1:0] b, bit cin, bit [3:0] s, bit sr, bit sl);
    @(posedge clk); #1;
    a8 = a; b8 = b; cin8 = cin; s8 = s; sr8 = sr; sl8 = sl;
    @(negedge clk);
    compare(req_of(s), {co8, f8}, model(WA, a, b, cin, s, sr, sl));
  endtask

  task automatic run3(logic [WB-1:0] a, logic [WB-1:0] b, bit cin, bit [3:0] s, bit sr, bit sl);
    @(posedge clk); #1;
    a3 = a; b3 = b; cin3 = cin; s3 = s; sr3 = sr; sl3 = sl;
    @(negedge clk);
    compare(req_of(s), {co3, f3}, model(WB, a, b, cin, s, sr, sl));
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [WA-1:0] ref_f;
    a8 = '0; b8 = '0; cin8 = 0; s8 = '0; sr8 = 0; sl8 = 0;
    a3 = '0; b3 = '0; cin3 = 0; s3 = '0; sr3 = 0; sl3 = 0;

    // idle state: all-zero inputs give zero result, R1
    @(negedge clk);
    compare("R1", {co8, f8}, 0);

    // directed corners on the wide instance
    run8(8'hFF, 8'h01, 0, 4'b0000, 0, 0);  // R1 wrap with carry
    run8(8'hFF, 8'hFF, 1, 4'b0000, 0, 0);  // R1 add plus one
    run8(8'h40, 8'h40, 1, 4'b0001, 0, 0);  // R2 A==B
    run8(8'h40, 8'h41, 1, 4'b0001, 0, 0);  // R2 A<B two's complement
    run8(8'h41, 8'h40, 0, 4'b0001, 0, 0);  // R2 subtract with borrow
    run8(8'hFF, 8'h00, 1, 4'b0010, 0, 0);  // R3 increment wraps
    run8(8'h00, 8'h00, 0, 4'b0011, 0, 0);  // R4 decrement of zero
    run8(8'h69, 8'hAA, 1, 4'b0100, 0, 0);  // R5 AND
    run8(8'h81, 8'h00, 0, 4'b1000, 1, 0);  // R6 fill one at MSB
    run8(8'h81, 8'h00, 0, 4'b1100, 0, 1);  // R7 fill one at LSB

    // R8: shift result independent of sel_i[1:0], cin_i and the opposite fill
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #1;
      a8 = 8'hB6; b8 = 8'h5C; s8 = {2'b10, k[1:0]}; cin8 = k[2]; sr8 = 1; sl8 = k[3];
      @(negedge clk);
      ref_f = 8'hDB;
      compare("R8", {co8, f8}, {1'b0, ref_f});
      @(posedge clk); #1;
      s8 = {2'b11, k[1:0]}; sr8 = k[3]; sl8 = 0;
      @(negedge clk);
      ref_f = 8'h6C;
      compare("R8", {co8, f8}, {1'b0, ref_f});
    end

    // exhaustive sweep of the narrow instance
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int s = 0; s < 16; s++)
          for (int x = 0; x < 8; x++)
            run3(a[2:0], b[2:0], x[0], s[3:0], x[1], x[2]);

    // pseudo-random run on the wide instance
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] q = $urandom;
      run8(r[7:0], r[15:8], r[16], r[20:17], q[0], q[1]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule